// File: doc/BRIEF.md
# UART Host Register Interface with Interrupt Control

This block sits between a host bus and the serial datapath of one 16550-style UART channel. The host reaches it through a 3-bit address, a read strobe and a write strobe. Behind that address space sit the interrupt enable, line control, modem control, line status, modem status and scratch registers. It also holds a write-only FIFO control register, a read-only interrupt identification register, and the receive buffer and transmit holding registers, which share address 0. When bit 7 of line control (the bank bit) is set, addresses 0 and 1 reach the low and high bytes of the 16-bit baud divisor instead of their normal registers.

The receive side hands in one byte at a time, with error flags, on a valid pulse. The transmit side sees a load pulse with the holding byte, and reports back when it takes that byte and while it is shifting. Four interrupt sources are ranked and reported through the identification register and a level interrupt output. Each source has its own clearing action. The block also drives the active-low modem control outputs and the serial line output, whose level a break bit can force. It issues clear pulses to the receive and transmit FIFOs.

Top module: `uart_host_regs`

## Requirements
- R1: Reset values: interrupt enable, line control, modem control = 0x00; identification = 0x01; line status = 0x60; modem status bits 3:0 = 0 with bits 7:4 following the pins; rts_n, dtr_n, out1_n, out2_n and txd = 1; irq = 0.
- R2: With the bank bit (line control bit 7) low, registers sit at these addresses: interrupt enable at 1 (bits 3:0 writable, 7:4 read 0), line control at 3, modem control at 4 (bits 3:0), scratch at 7. Each reads back what was written.
- R3: With the bank bit high, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8. Such accesses leave the transmit holding register and interrupt enable untouched. The divisor appears on the `divisor` port.
- R4: A write to address 0 with the bank bit low gives a one-cycle `tx_load` pulse, with the byte on `tx_byte`, and clears line status bit 5 (holding empty). `tx_take` sets bit 5. Bit 6 equals bit 5 and not `tx_busy`.
- R5: A `rx_valid` pulse stores `rx_byte` and sets line status bit 0 (data ready). A read of address 0 with the bank bit low returns the byte and clears bit 0.
- R6: A `rx_valid` while data ready is already set sets line status bit 1 (overrun). `rx_err` bits 0, 1 and 2 (parity, framing, break) set line status bits 2, 3 and 4. A read of line status (address 5) clears bits 4:1.
- R7: The transmitter-empty interrupt goes pending when `tx_take` empties a full holding register, or when interrupt enable bit 1 is written from 0 to 1 while the holding register is empty. It clears on a transmit holding write, or on a read of identification (address 2) that reports it.
- R8: Identification bits 3:1 report the highest-ranked enabled pending source. Line status error (enable bit 2) gives 0x06, data ready (enable bit 0) gives 0x04, transmitter empty (enable bit 1) gives 0x02, and a modem delta (enable bit 3) gives 0x00. Bit 0 is 1 when nothing is pending, and bits 7:6 both equal the FIFO enable bit.
- R9: `irq` is high exactly one cycle after an enabled source is pending, and low one cycle after none is.
- R10: Modem status bits 4 to 7 are the synchronized, inverted cts_n, dsr_n, ri_n and dcd_n. Bits 0, 1 and 3 set on any change of cts, dsr or dcd. Bit 2 sets when ri_n returns high. A read of modem status (address 6) clears bits 3:0.
- R11: Modem control bits 0 to 3 drive dtr_n, rts_n, out1_n and out2_n inverted.
- R12: A write to address 2 with data bit 0 = 0, or with bits 1:0 = 11, gives a one-cycle pulse on both `rx_fifo_clr` and `tx_fifo_clr`. Data 01 gives no pulse. Both outputs are high while reset is held. Data bit 0 is kept as FIFO enable.
- R13: `word_len` equals line control bits 1:0. `txd` follows `ser_out` one cycle later, and is driven low while line control bit 6 (break) is set.
- R14: `rd_data` is registered: it shows the selected register one cycle after `rd_en` and holds its value when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |
| rx_valid | input | 1 | New received byte pulse |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 3 | Error flags with the byte: {break, framing, parity} |
| tx_byte | output | 8 | Transmit holding byte |
| tx_load | output | 1 | Holding register written pulse |
| tx_take | input | 1 | Transmitter took the holding byte |
| tx_busy | input | 1 | Transmitter shifting |
| ser_out | input | 1 | Serializer output bit |
| txd | output | 1 | Serial line output |
| word_len | output | 2 | Word length select (5 to 8 bits) |
| divisor | output | 16 | Baud divisor |
| rx_fifo_clr | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO clear pulse |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |

## Verification
The address decode is driven with the same addresses under both bank-bit values. This separates a divisor access from a holding-register load or an interrupt enable write. Receive pulses are sent alone, back to back and with each error flag. These cases tell data ready from overrun and show which line-status read clears which bits. Several sources are made pending together, then retired one by one through their own clearing accesses, which shows the ranking and that each clear touches only its source. Modem pins are toggled one at a time to separate the change-detect deltas from the ring trailing-edge rule. FIFO control is written with 00, 01, 11 and 10 in bits 1:0 to show which writes produce clear pulses.

// File: rtl/uart_hr_pkg.sv
package uart_hr_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_IEN  = 3'd1;
  localparam logic [2:0] A_IDF  = 3'd2;
  localparam logic [2:0] A_LCTL = 3'd3;
  localparam logic [2:0] A_MCTL = 3'd4;
  localparam logic [2:0] A_LSTA = 3'd5;
  localparam logic [2:0] A_MSTA = 3'd6;
  localparam logic [2:0] A_SCR  = 3'd7;

  // identification codes in bits 3:1, ranked highest first
  localparam logic [2:0] ID_LINE = 3'b011;
  localparam logic [2:0] ID_RXD  = 3'b010;
  localparam logic [2:0] ID_THRE = 3'b001;
  localparam logic [2:0] ID_MDM  = 3'b000;

  typedef struct packed {
    logic rd_rbr, wr_thr;
    logic rd_ier, wr_ier;
    logic rd_iir, wr_fcr;
    logic rd_lcr, wr_lcr;
    logic rd_mcr, wr_mcr;
    logic rd_lsr, rd_msr;
    logic rd_scr, wr_scr;
    logic rd_dll, wr_dll;
    logic rd_dlm, wr_dlm;
  } acc_t;
endpackage

// File: rtl/uart_hr_decode.sv
module uart_hr_decode
  import uart_hr_pkg::*;
(
  input  logic [2:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic       bank,
  output acc_t       acc
);
  always_comb begin
    acc = '0;
    case (addr)
      A_DATA: begin
        if (bank) begin
          acc.rd_dll = rd_en;
          acc.wr_dll = wr_en;
        end else begin
          acc.rd_rbr = rd_en;
          acc.wr_thr = wr_en;
        end
      end
      A_IEN: begin
        if (bank) begin
          acc.rd_dlm = rd_en;
          acc.wr_dlm = wr_en;
        end else begin
          acc.rd_ier = rd_en;
          acc.wr_ier = wr_en;
        end
      end
      A_IDF: begin
        acc.rd_iir = rd_en;
        acc.wr_fcr = wr_en;
      end
      A_LCTL: begin
        acc.rd_lcr = rd_en;
        acc.wr_lcr = wr_en;
      end
      A_MCTL: begin
        acc.rd_mcr = rd_en;
        acc.wr_mcr = wr_en;
      end
      A_LSTA:  acc.rd_lsr = rd_en;
      A_MSTA:  acc.rd_msr = rd_en;
      default: begin
        acc.rd_scr = rd_en;
        acc.wr_scr = wr_en;
      end
    endcase
  end
endmodule

// File: rtl/uart_hr_line.sv
module uart_hr_line #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic [2:0]    rx_err,
  input  logic          rd_rbr,
  input  logic          rd_lsr,
  input  logic          wr_thr,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_take,
  input  logic          tx_busy,
  output logic [DW-1:0] rbr,
  output logic [7:0]    lsr,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load,
  output logic          thr_empty,
  output logic          thre_set
);
  logic [DW-1:0] rbr_q, thr_q;
  logic          dr_q, oe_q, empty_q, load_q;
  logic [2:0]    err_q;
  logic          ovr;

  assign ovr      = rx_valid && dr_q && !rd_rbr;
  assign thre_set = tx_take && !empty_q && !wr_thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbr_q   <= '0;
      thr_q   <= '0;
      dr_q    <= 1'b0;
      oe_q    <= 1'b0;
      err_q   <= '0;
      empty_q <= 1'b1;
      load_q  <= 1'b0;
    end else begin
      load_q <= wr_thr;
      if (wr_thr) begin
        thr_q   <= wr_data;
        empty_q <= 1'b0;
      end else if (tx_take) begin
        empty_q <= 1'b1;
      end
      if (rx_valid) begin
        rbr_q <= rx_byte;
        dr_q  <= 1'b1;
      end else if (rd_rbr) begin
        dr_q <= 1'b0;
      end
      // a new event in the same cycle as a status read is kept
      if (ovr)         oe_q <= 1'b1;
      else if (rd_lsr) oe_q <= 1'b0;
      if (rx_valid)    err_q <= rx_err | (rd_lsr ? 3'b000 : err_q);
      else if (rd_lsr) err_q <= 3'b000;
    end
  end

  assign rbr       = rbr_q;
  assign tx_byte   = thr_q;
  assign tx_load   = load_q;
  assign thr_empty = empty_q;
  assign lsr       = {1'b0, empty_q & ~tx_busy, empty_q, err_q, oe_q, dr_q};
endmodule

// File: rtl/uart_hr_modem.sv
module uart_hr_modem #(
  parameter int SYNC   = 2,
  parameter int NPINS  = 4,
  parameter int RI_IDX = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_n,
  input  logic             rd_msr,
  output logic [NPINS-1:0] status,
  output logic [NPINS-1:0] delta
);
  localparam int DEPTH = SYNC + 1;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [DEPTH-1:0] chain;
    logic             hit;
    logic             dq;

    always_ff @(posedge clk) begin
      if (rst) chain <= {DEPTH{pins_n[i]}};
      else     chain <= {chain[DEPTH-2:0], pins_n[i]};
    end

    if (i == RI_IDX) begin : g_trail
      // ring reported when the pin returns to its inactive level
      assign hit = !chain[DEPTH-1] && chain[DEPTH-2];
    end else begin : g_change
      assign hit = chain[DEPTH-1] ^ chain[DEPTH-2];
    end

    always_ff @(posedge clk) begin
      if (rst)         dq <= 1'b0;
      else if (hit)    dq <= 1'b1;
      else if (rd_msr) dq <= 1'b0;
    end

    assign status[i] = ~chain[DEPTH-1];
    assign delta[i]  = dq;
  end
endmodule

// File: rtl/uart_hr_irq.sv
module uart_hr_irq
  import uart_hr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] ien,
  input  logic       data_rdy,
  input  logic       line_err,
  input  logic       mdm_delta,
  input  logic       thre_set,
  input  logic       thre_arm,
  input  logic       wr_thr,
  input  logic       rd_iir,
  input  logic       fifo_en,
  output logic [7:0] iir,
  output logic       irq
);
  logic       thre_q, irq_q;
  logic       src_line, src_rxd, src_thre, src_mdm, none;
  logic [2:0] id;

  assign src_line = line_err  & ien[2];
  assign src_rxd  = data_rdy  & ien[0];
  assign src_thre = thre_q    & ien[1];
  assign src_mdm  = mdm_delta & ien[3];
  assign none     = !(src_line || src_rxd || src_thre || src_mdm);

  always_comb begin
    if (src_line)      id = ID_LINE;
    else if (src_rxd)  id = ID_RXD;
    else if (src_thre) id = ID_THRE;
    else               id = ID_MDM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thre_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= !none;
      if (wr_thr)                                      thre_q <= 1'b0;
      else if (thre_set || thre_arm)                   thre_q <= 1'b1;
      else if (rd_iir && src_thre && !src_line && !src_rxd) thre_q <= 1'b0;
    end
  end

  assign iir = {fifo_en, fifo_en, 2'b00, id, none};
  assign irq = irq_q;
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_hr_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic [2:0]    rx_err,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load,
  input  logic          tx_take,
  input  logic          tx_busy,
  input  logic          ser_out,
  output logic          txd,
  output logic [1:0]    word_len,
  output logic [2*DW-1:0] divisor,
  output logic          rx_fifo_clr,
  output logic          tx_fifo_clr,
  input  logic          cts_n,
  input  logic          dsr_n,
  input  logic          ri_n,
  input  logic          dcd_n,
  output logic          rts_n,
  output logic          dtr_n,
  output logic          out1_n,
  output logic          out2_n
);
  localparam int NPINS = 4;

  acc_t          acc;
  logic [DW-1:0] lcr_q, scr_q, dll_q, dlm_q, rd_q, rd_mux;
  logic [3:0]    ier_q, mcr_q;
  logic          fifo_en_q, rxc_q, txc_q, txd_q;
  logic          bank, fcr_clr, thre_arm;
  logic [DW-1:0] rbr;
  logic [7:0]    lsr, iir;
  logic          thr_empty, thre_set;
  logic [NPINS-1:0] mstat, mdelta;

  assign bank = lcr_q[7];

  uart_hr_decode i_dec (
    .addr  (addr),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .bank  (bank),
    .acc   (acc)
  );

  uart_hr_line #(.DW(DW)) i_line (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_err    (rx_err),
    .rd_rbr    (acc.rd_rbr),
    .rd_lsr    (acc.rd_lsr),
    .wr_thr    (acc.wr_thr),
    .wr_data   (wr_data),
    .tx_take   (tx_take),
    .tx_busy   (tx_busy),
    .rbr       (rbr),
    .lsr       (lsr),
    .tx_byte   (tx_byte),
    .tx_load   (tx_load),
    .thr_empty (thr_empty),
    .thre_set  (thre_set)
  );

  uart_hr_modem #(.SYNC(SYNC), .NPINS(NPINS), .RI_IDX(2)) i_mdm (
    .clk    (clk),
    .rst    (rst),
    .pins_n ({dcd_n, ri_n, dsr_n, cts_n}),
    .rd_msr (acc.rd_msr),
    .status (mstat),
    .delta  (mdelta)
  );

  // enabling the empty interrupt while the holding register is empty arms it
  assign thre_arm = acc.wr_ier && wr_data[1] && !ier_q[1] && thr_empty;

  uart_hr_irq i_irq (
    .clk       (clk),
    .rst       (rst),
    .ien       (ier_q),
    .data_rdy  (lsr[0]),
    .line_err  (|lsr[4:1]),
    .mdm_delta (|mdelta),
    .thre_set  (thre_set),
    .thre_arm  (thre_arm),
    .wr_thr    (acc.wr_thr),
    .rd_iir    (acc.rd_iir),
    .fifo_en   (fifo_en_q),
    .iir       (iir),
    .irq       (irq)
  );

  assign fcr_clr = acc.wr_fcr && (!wr_data[0] || (wr_data[1:0] == 2'b11));

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q     <= '0;
      scr_q     <= '0;
      dll_q     <= '0;
      dlm_q     <= '0;
      ier_q     <= '0;
      mcr_q     <= '0;
      fifo_en_q <= 1'b0;
    end else begin
      if (acc.wr_lcr) lcr_q     <= wr_data;
      if (acc.wr_scr) scr_q     <= wr_data;
      if (acc.wr_dll) dll_q     <= wr_data;
      if (acc.wr_dlm) dlm_q     <= wr_data;
      if (acc.wr_ier) ier_q     <= wr_data[3:0];
      if (acc.wr_mcr) mcr_q     <= wr_data[3:0];
      if (acc.wr_fcr) fifo_en_q <= wr_data[0];
    end
  end

  // clear pulses are held high through reset
  always_ff @(posedge clk) begin
    rxc_q <= rst || fcr_clr;
    txc_q <= rst || fcr_clr;
    txd_q <= rst || (!lcr_q[6] && ser_out);
  end

  always_comb begin
    case (addr)
      A_DATA:  rd_mux = bank ? dll_q : rbr;
      A_IEN:   rd_mux = bank ? dlm_q : {{(DW-4){1'b0}}, ier_q};
      A_IDF:   rd_mux = iir;
      A_LCTL:  rd_mux = lcr_q;
      A_MCTL:  rd_mux = {{(DW-4){1'b0}}, mcr_q};
      A_LSTA:  rd_mux = lsr;
      A_MSTA:  rd_mux = {mstat, mdelta};
      default: rd_mux = scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data     = rd_q;
  assign rx_fifo_clr = rxc_q;
  assign tx_fifo_clr = txc_q;
  assign txd         = txd_q;
  assign word_len    = lcr_q[1:0];
  assign divisor     = {dlm_q, dll_q};
  assign dtr_n       = ~mcr_q[0];
  assign rts_n       = ~mcr_q[1];
  assign out1_n      = ~mcr_q[2];
  assign out2_n      = ~mcr_q[3];
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [1:0] wd_lo,
  input logic       bank,
  input logic       dr,
  input logic       iir_none,
  input logic       irq,
  input logic       tx_load,
  input logic       rx_valid,
  input logic       rx_fifo_clr,
  input logic       tx_fifo_clr
);
  logic clr_req;
  assign clr_req = wr_en && (addr == 3'd2) && (!wd_lo[0] || (wd_lo == 2'b11));

  a_r4_thr_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0 && !bank) |=> tx_load);

  a_r3_bank_no_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0 && bank) |=> !tx_load);

  a_r5_data_ready: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> dr);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd0 && !bank && !rx_valid) |=> !dr);

  a_r12_clr_pulse: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (rx_fifo_clr && tx_fifo_clr));

  a_r12_no_clr: assert property (@(posedge clk) disable iff (rst)
    !clr_req |=> (!rx_fifo_clr && !tx_fifo_clr));

  a_r9_irq_idle: assert property (@(posedge clk) disable iff (rst)
    iir_none |=> !irq);

  a_r9_irq_pend: assert property (@(posedge clk) disable iff (rst)
    !iir_none |=> irq);
endmodule

bind uart_host_regs uart_host_regs_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .addr        (addr),
  .rd_en       (rd_en),
  .wr_en       (wr_en),
  .wd_lo       (wr_data[1:0]),
  .bank        (bank),
  .dr          (lsr[0]),
  .iir_none    (iir[0]),
  .irq         (irq),
  .tx_load     (tx_load),
  .rx_valid    (rx_valid),
  .rx_fifo_clr (rx_fifo_clr),
  .tx_fifo_clr (tx_fifo_clr)
);

// File: tb/test_uart_host_regs.sv
`timescale 1ns/1ps
module test_uart_host_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = '0, rd_data;
  logic        irq;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [2:0]  rx_err = '0;
  logic [7:0]  tx_byte;
  logic        tx_load;
  logic        tx_take = 1'b0, tx_busy = 1'b0, ser_out = 1'b1;
  logic        txd;
  logic [1:0]  word_len;
  logic [15:0] divisor;
  logic        rx_fifo_clr, tx_fifo_clr;
  logic        cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic        rts_n, dtr_n, out1_n, out2_n;

  int n_chk = 0, n_fail = 0;
  int load_cnt = 0, rxc_cnt = 0, txc_cnt = 0;
  logic [7:0] last_tx = '0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  uart_host_regs i_uart_host_regs (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_err(rx_err),
    .tx_byte(tx_byte), .tx_load(tx_load), .tx_take(tx_take), .tx_busy(tx_busy),
    .ser_out(ser_out), .txd(txd), .word_len(word_len), .divisor(divisor),
    .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .rts_n(rts_n), .dtr_n(dtr_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_load) begin load_cnt++; last_tx = tx_byte; end
      if (rx_fifo_clr) rxc_cnt++;
      if (tx_fifo_clr) txc_cnt++;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic rx_pulse(logic [7:0] b, logic [2:0] e);
    @(negedge clk);
    rx_byte = b; rx_err = e; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = '0;
  endtask

  task automatic take_pulse();
    @(negedge clk);
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pins in reset", {12'h0, rts_n, dtr_n, out1_n, out2_n}, 16'hF);
    chk("R1 txd in reset", {15'h0, txd}, 16'h1);
    chk("R12 clr in reset", {14'h0, rx_fifo_clr, tx_fifo_clr}, 16'h3);
    @(negedge clk);
    rst = 1'b0;
    idle(1);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    rd_chk("R1 ier", 3'd1, 8'h00);
    rd_chk("R1 iir", 3'd2, 8'h01);
    rd_chk("R1 lcr", 3'd3, 8'h00);
    rd_chk("R1 mcr", 3'd4, 8'h00);
    rd_chk("R1 lsr", 3'd5, 8'h60);
    rd_chk("R1 msr", 3'd6, 8'h00);
  endtask

  task automatic t_regs();
    wr(3'd7, 8'hA5);
    rd_chk("R2 scratch", 3'd7, 8'hA5);
    wr(3'd3, 8'h1B);
    chk("R14 rd_data held", {8'h0, rd_data}, 16'h00A5);
    rd_chk("R2 lcr", 3'd3, 8'h1B);
    wr(3'd3, 8'h00);
    wr(3'd1, 8'hF5);
    rd_chk("R2 ier upper bits zero", 3'd1, 8'h05);
  endtask

  task automatic t_divisor();
    int c0;
    c0 = load_cnt;
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    idle(1);
    chk("R3 divisor", divisor, 16'h1234);
    chk("R3 no tx_load", 16'(load_cnt - c0), 16'h0);
    rd_chk("R3 dll", 3'd0, 8'h34);
    rd_chk("R3 dlm", 3'd1, 8'h12);
    wr(3'd3, 8'h03);
    rd_chk("R3 ier untouched", 3'd1, 8'h05);
    rd_chk("R3 rbr untouched", 3'd0, 8'h00);
  endtask

  task automatic t_tx();
    int c0;
    wr(3'd1, 8'h02);
    idle(1);
    chk("R7 irq on enable", {15'h0, irq}, 16'h1);
    rd_chk("R7 iir thre", 3'd2, 8'h02);
    rd_chk("R7 iir cleared by read", 3'd2, 8'h01);
    idle(1);
    chk("R9 irq low", {15'h0, irq}, 16'h0);
    c0 = load_cnt;
    wr(3'd0, 8'h5A);
    idle(1);
    chk("R4 one load", 16'(load_cnt - c0), 16'h1);
    chk("R4 tx byte", {8'h0, last_tx}, 16'h005A);
    rd_chk("R4 lsr full", 3'd5, 8'h00);
    tx_busy = 1'b1;
    take_pulse();
    rd_chk("R4 lsr empty busy", 3'd5, 8'h20);
    tx_busy = 1'b0;
    rd_chk("R4 lsr idle", 3'd5, 8'h60);
    rd_chk("R7 iir after take", 3'd2, 8'h02);
    take_pulse();
    wr(3'd0, 8'h11);
    take_pulse();
    wr(3'd0, 8'h22);
    rd_chk("R7 cleared by thr write", 3'd2, 8'h01);
    take_pulse();
    rd_chk("R7 set by take", 3'd2, 8'h02);
  endtask

  task automatic t_rx();
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h07);
    idle(1);
    chk("R9 irq thre", {15'h0, irq}, 16'h1);
    rx_pulse(8'h3C, 3'b000);
    rd_chk("R8 rx over thre", 3'd2, 8'h04);
    rd_chk("R5 lsr dr", 3'd5, 8'h61);
    rx_pulse(8'h7E, 3'b001);
    rd_chk("R8 line first", 3'd2, 8'h06);
    rd_chk("R6 overrun parity", 3'd5, 8'h67);
    rd_chk("R6 lsr read clears", 3'd5, 8'h61);
    rd_chk("R8 back to rx", 3'd2, 8'h04);
    rd_chk("R5 rbr latest", 3'd0, 8'h7E);
    rd_chk("R5 dr cleared", 3'd5, 8'h60);
    rd_chk("R8 thre last", 3'd2, 8'h02);
    rd_chk("R7 cleared", 3'd2, 8'h01);
    rx_pulse(8'h00, 3'b110);
    rd_chk("R6 framing break", 3'd5, 8'h79);
    rd_chk("R5 rbr", 3'd0, 8'h00);
    rd_chk("R6 cleared", 3'd5, 8'h60);
    idle(1);
    chk("R9 irq idle", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_modem();
    wr(3'd1, 8'h08);
    rd_chk("R10 msr quiet", 3'd6, 8'h00);
    @(negedge clk) cts_n = 1'b0;
    idle(5);
    chk("R10 irq modem", {15'h0, irq}, 16'h1);
    rd_chk("R8 iir modem", 3'd2, 8'h00);
    rd_chk("R10 cts delta", 3'd6, 8'h11);
    rd_chk("R10 delta cleared", 3'd6, 8'h10);
    @(negedge clk) ri_n = 1'b0;
    idle(5);
    rd_chk("R10 ri lead no delta", 3'd6, 8'h50);
    @(negedge clk) ri_n = 1'b1;
    idle(5);
    rd_chk("R10 ri trailing", 3'd6, 8'h14);
    @(negedge clk) dcd_n = 1'b0;
    idle(5);
    rd_chk("R10 dcd delta", 3'd6, 8'h98);
    rd_chk("R10 dcd cleared", 3'd6, 8'h90);
  endtask

  task automatic t_mcr();
    wr(3'd4, 8'h0F);
    chk("R11 all active", {12'h0, dtr_n, rts_n, out1_n, out2_n}, 16'h0);
    wr(3'd4, 8'h05);
    chk("R11 mixed", {12'h0, dtr_n, rts_n, out1_n, out2_n}, 16'h5);
    rd_chk("R2 mcr", 3'd4, 8'h05);
  endtask

  task automatic t_fcr();
    int r0, t0;
    r0 = rxc_cnt; t0 = txc_cnt;
    wr(3'd2, 8'h01);
    idle(1);
    chk("R12 01 no pulse", 16'((rxc_cnt - r0) + (txc_cnt - t0)), 16'h0);
    rd_chk("R8 fifo bits", 3'd2, 8'hC1);
    wr(3'd2, 8'h03);
    idle(1);
    chk("R12 11 rx pulse", 16'(rxc_cnt - r0), 16'h1);
    chk("R12 11 tx pulse", 16'(txc_cnt - t0), 16'h1);
    wr(3'd2, 8'h00);
    idle(1);
    chk("R12 00 pulse", 16'((rxc_cnt - r0) + (txc_cnt - t0)), 16'h4);
    rd_chk("R12 fifo off", 3'd2, 8'h01);
    wr(3'd2, 8'h02);
    idle(1);
    chk("R12 10 pulse", 16'(rxc_cnt - r0), 16'h3);
  endtask

  task automatic t_line();
    wr(3'd3, 8'h02);
    chk("R13 word len", {14'h0, word_len}, 16'h2);
    @(negedge clk) ser_out = 1'b0;
    @(negedge clk);
    chk("R13 txd low", {15'h0, txd}, 16'h0);
    ser_out = 1'b1;
    @(negedge clk);
    chk("R13 txd high", {15'h0, txd}, 16'h1);
    wr(3'd3, 8'h42);
    idle(1);
    chk("R13 break", {15'h0, txd}, 16'h0);
    wr(3'd3, 8'h03);
    idle(1);
    chk("R13 break off", {15'h0, txd}, 16'h1);
    chk("R13 word len 8", {14'h0, word_len}, 16'h3);
  endtask

  initial begin
    idle(3);
    t_reset();
    t_regs();
    t_divisor();
    t_tx();
    t_rx();
    t_modem();
    t_mcr();
    t_fcr();
    t_line();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule